// File: doc/BRIEF.md
# Multi-Mode Bus Timeout Counter

This block is an 8-bit down-counting watchdog with three selectable modes. A command from the host starts each mode. The first mode waits for the attention line to be released after a take-control request. The second mode watches for activity edges on a count input after a standby or event-counter start. The third mode waits for the data-valid line to go false after a synchronous take-control request. The first and third modes step on a slow prescaler strobe of about 4.5 ms. The second mode steps on a fast strobe of about 113 µs. Both strobes arrive as one-cycle enable pulses.

The host loads the reload value through a two-step command-then-data write. It can read the live count, the error flags and the error mask. A flag is set when a watchdog run expires. A separate user-error flag is set when the host asks for a system-controller-only action while the device does not hold that role. A clear command stops monitoring and drops every flag. The block raises an error interrupt request when a flag is set and its mask bit is also set. It also provides an unmasked pending output.

Top module: `bus_timeout_unit`

## Requirements
- R1: After command E1h, the next data write loads the 8-bit reload register. A data write that is not preceded by E1h leaves the reload value unchanged. No command reads the reload register back.
- R2: The read commands select what `rd_data` shows from the following edge onward: E9h shows the live count, E4h the error flags and EAh the mask. The flag and mask layout is bit 0 = mode-1 timeout, bit 1 = mode-2 timeout, bit 2 = mode-3 timeout and bit 5 = user error. Bits 3, 4, 6 and 7 always read 0.
- R3: A start command copies the reload value into the live count. A reload of 00h gives 256 steps before expiry, and 01h to FFh give 1 to 255 steps.
- R4: Command FAh starts mode 1. The count drops by one on each slow strobe. The step that brings the count to 0 sets flag bit 0. The run ends without a flag if `atn_active` is low.
- R5: Command F4h or F6h starts mode 2. The count drops on each fast strobe, and a high-to-low edge on `cnt_in` reloads it (the reload wins over a strobe). Reaching 0 sets flag bit 1, and counting then continues in 256-step periods.
- R6: Command FDh starts mode 3. The count drops on each slow strobe while `dav_active` is high. Reaching 0 sets flag bit 2.
- R7: After a mode-1 or mode-3 expiry, the count stays at 0 and monitoring goes on until the watched line goes low. Read and reload-write commands issued in the meantime do not end the run. A strobe of the other rate never changes the count.
- R8: Command F3h stops any run and clears all flags. The live count is left as it was.
- R9: While no run is active, the live count keeps the value it last reached.
- R10: A `ctl_req` pulse while `sys_ctrl` is low sets flag bit 5. While `sys_ctrl` is high, the pulse has no effect.
- R11: `mask_we` writes the mask directly. `err_irq` is high exactly when some flag bit and its mask bit are both 1. `err_pending` is high when any flag bit is 1.
- R12: After reset, `rd_data`, `err_irq` and `err_pending` are 0, the reload value is 00h and no run is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 8 | Data write value |
| mask_we | input | 1 | Direct mask write strobe |
| mask_wdata | input | 8 | Mask write value |
| tick_slow | input | 1 | Slow prescaler enable (modes 1 and 3) |
| tick_fast | input | 1 | Fast prescaler enable (mode 2) |
| atn_active | input | 1 | Attention line asserted |
| dav_active | input | 1 | Data-valid line asserted |
| cnt_in | input | 1 | Activity input, falling edge counts |
| ctl_req | input | 1 | Host request for a system-controller-only action |
| sys_ctrl | input | 1 | Device is the system controller |
| rd_data | output | 8 | Selected read value |
| err_pending | output | 1 | Any error flag set |
| err_irq | output | 1 | Masked error interrupt request |

## Verification
The assertions assume that a command strobe and a data write never arrive in the same cycle. They also assume that mask writes keep the reserved bits 3, 4, 6 and 7 at zero, and that `ctl_req` never coincides with the clear command. The stimulus drives exactly one host action per cycle and only ever writes mask values built from the four defined bits. It changes the level inputs (`cnt_in`, `atn_active`, `dav_active`, `sys_ctrl`) only between clock edges, so every activity edge is seen in exactly one cycle.

// File: rtl/bto_pkg.sv
package bto_pkg;

    localparam int unsigned CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_WR_RELOAD = 8'hE1;
    localparam logic [CMD_W-1:0] CMD_RD_COUNT  = 8'hE9;
    localparam logic [CMD_W-1:0] CMD_RD_FLAGS  = 8'hE4;
    localparam logic [CMD_W-1:0] CMD_RD_MASK   = 8'hEA;
    localparam logic [CMD_W-1:0] CMD_GO_ATN    = 8'hFA;
    localparam logic [CMD_W-1:0] CMD_GO_EVT    = 8'hF4;
    localparam logic [CMD_W-1:0] CMD_GO_SBY    = 8'hF6;
    localparam logic [CMD_W-1:0] CMD_GO_DAV    = 8'hFD;
    localparam logic [CMD_W-1:0] CMD_CLR_ERR   = 8'hF3;

    localparam int FB_T1   = 0;
    localparam int FB_T2   = 1;
    localparam int FB_T3   = 2;
    localparam int FB_USER = 5;
    localparam int N_WATCH = 3;

    localparam logic [7:0] FLAG_KEEP =
        8'((1 << FB_T1) | (1 << FB_T2) | (1 << FB_T3) | (1 << FB_USER));

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_ATN,
        MODE_ACT,
        MODE_DAV
    } tmode_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CNT,
        SEL_FLAGS,
        SEL_MASK
    } rsel_e;

    typedef struct packed {
        logic   start;
        tmode_e mode;
        logic   clr;
        logic   arm;
        logic   sel_upd;
        rsel_e  sel;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] code);
        cmd_dec_t d;
        d = '0;
        d.mode = MODE_IDLE;
        d.sel  = SEL_NONE;
        case (code)
            CMD_WR_RELOAD: d.arm = 1'b1;
            CMD_RD_COUNT:  begin d.sel_upd = 1'b1; d.sel = SEL_CNT;   end
            CMD_RD_FLAGS:  begin d.sel_upd = 1'b1; d.sel = SEL_FLAGS; end
            CMD_RD_MASK:   begin d.sel_upd = 1'b1; d.sel = SEL_MASK;  end
            CMD_GO_ATN:    begin d.start = 1'b1; d.mode = MODE_ATN; end
            CMD_GO_EVT,
            CMD_GO_SBY:    begin d.start = 1'b1; d.mode = MODE_ACT; end
            CMD_GO_DAV:    begin d.start = 1'b1; d.mode = MODE_DAV; end
            CMD_CLR_ERR:   d.clr = 1'b1;
            default:       d = d;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bto_host_if.sv
module bto_host_if
    import bto_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_wdata,
    output cmd_dec_t          dec,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] mask_q,
    output rsel_e             sel_q
);

    cmd_dec_t raw_dec;
    logic     armed_q;

    assign raw_dec = decode_cmd(cmd_code);
    assign dec     = cmd_valid ? raw_dec : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            reload_q <= '0;
            mask_q   <= '0;
            sel_q    <= SEL_NONE;
        end else begin
            if (cmd_valid) begin
                armed_q <= raw_dec.arm;
            end else if (wr_valid && armed_q) begin
                armed_q  <= 1'b0;
                reload_q <= wr_data;
            end
            if (dec.sel_upd) begin
                sel_q <= dec.sel;
            end
            if (mask_we) begin
                mask_q <= mask_wdata & DATA_W'(FLAG_KEEP);
            end
        end
    end

    // R1
    arm_once_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && armed_q && !cmd_valid) |=> !armed_q);

    // R1
    reload_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !cmd_valid) |=> $stable(reload_q));

endmodule

// File: rtl/bto_countdown.sv
module bto_countdown
    import bto_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  tmode_e             start_mode,
    input  logic               clr,
    input  logic [CNT_W-1:0]   reload,
    input  logic               tick_slow,
    input  logic               tick_fast,
    input  logic               atn_active,
    input  logic               dav_active,
    input  logic               cnt_in,
    output logic [CNT_W-1:0]   cnt_q,
    output tmode_e             mode_q,
    output logic [N_WATCH-1:0] expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             prev_in_q;
    logic             act_edge;
    logic             done_q, done_d;
    logic [CNT_W-1:0] cnt_d;
    tmode_e           mode_d;
    logic             line_ok;
    logic             step;

    assign act_edge = prev_in_q && !cnt_in;

    always_comb begin
        line_ok = 1'b0;
        step    = 1'b0;
        case (mode_q)
            MODE_ATN: begin line_ok = atn_active; step = tick_slow; end
            MODE_DAV: begin line_ok = dav_active; step = tick_slow; end
            MODE_ACT: begin line_ok = 1'b1;       step = tick_fast; end
            default:  begin line_ok = 1'b0;       step = 1'b0;      end
        endcase
    end

    always_comb begin
        mode_d = mode_q;
        cnt_d  = cnt_q;
        done_d = done_q;
        expire = '0;
        if (clr) begin
            mode_d = MODE_IDLE;
        end else if (start) begin
            mode_d = start_mode;
            cnt_d  = reload;
            done_d = 1'b0;
        end else if (mode_q != MODE_IDLE) begin
            if (!line_ok) begin
                mode_d = MODE_IDLE;
            end else if (mode_q == MODE_ACT && act_edge) begin
                cnt_d = reload;
            end else if (step && !done_q) begin
                cnt_d = cnt_q - ONE;
                if (cnt_q == ONE) begin
                    case (mode_q)
                        MODE_ATN: begin expire[0] = 1'b1; done_d = 1'b1; end
                        MODE_ACT: expire[1] = 1'b1;
                        default:  begin expire[2] = 1'b1; done_d = 1'b1; end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_IDLE;
            cnt_q     <= '0;
            done_q    <= 1'b0;
            prev_in_q <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            cnt_q     <= cnt_d;
            done_q    <= done_d;
            prev_in_q <= cnt_in;
        end
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_IDLE && !start) |=> $stable(cnt_q));

    // R4
    atn_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ATN && !atn_active && !start) |=> mode_q == MODE_IDLE);

    // R5
    edge_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ACT && act_edge && !start && !clr) |=> cnt_q == $past(reload));

    // R7
    expired_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !start) |=> cnt_q == '0);

    // R4
    one_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(expire));

endmodule

// File: rtl/bto_err_flags.sv
module bto_err_flags
    import bto_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_WATCH-1:0] expire,
    input  logic               user_set,
    input  logic               clr,
    input  logic [DATA_W-1:0]  mask,
    output logic [DATA_W-1:0]  flags_q,
    output logic               irq,
    output logic               pending
);

    localparam int WATCH_POS [N_WATCH] = '{FB_T1, FB_T2, FB_T3};

    logic [DATA_W-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < N_WATCH; i++) begin
            set_vec[WATCH_POS[i]] = expire[i];
        end
        set_vec[FB_USER] = user_set;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_q | set_vec;
        end
    end

    assign irq     = |(flags_q & mask);
    assign pending = |flags_q;

    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> flags_q == '0);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q[FB_T1] && !clr) |=> flags_q[FB_T1]);

    // R10
    user_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!flags_q[FB_USER] && !user_set) |=> !flags_q[FB_USER]);

    // R11
    irq_pend_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> pending);

endmodule

// File: rtl/bus_timeout_unit.sv
module bus_timeout_unit
    import bto_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              atn_active,
    input  logic              dav_active,
    input  logic              cnt_in,
    input  logic              ctl_req,
    input  logic              sys_ctrl,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_pending,
    output logic              err_irq
);

    cmd_dec_t           dec;
    logic [DATA_W-1:0]  reload_q;
    logic [DATA_W-1:0]  mask_q;
    rsel_e              sel_q;
    logic [DATA_W-1:0]  cnt_q;
    tmode_e             mode_q;
    logic [N_WATCH-1:0] expire;
    logic [DATA_W-1:0]  flags_q;
    logic               user_set;

    assign user_set = ctl_req && !sys_ctrl;

    bto_host_if #(.DATA_W(DATA_W)) host_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .dec        (dec),
        .reload_q   (reload_q),
        .mask_q     (mask_q),
        .sel_q      (sel_q)
    );

    bto_countdown #(.CNT_W(DATA_W)) count_i (
        .clk        (clk),
        .rst        (rst),
        .start      (dec.start),
        .start_mode (dec.mode),
        .clr        (dec.clr),
        .reload     (reload_q),
        .tick_slow  (tick_slow),
        .tick_fast  (tick_fast),
        .atn_active (atn_active),
        .dav_active (dav_active),
        .cnt_in     (cnt_in),
        .cnt_q      (cnt_q),
        .mode_q     (mode_q),
        .expire     (expire)
    );

    bto_err_flags #(.DATA_W(DATA_W)) flags_i (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .user_set (user_set),
        .clr      (dec.clr),
        .mask     (mask_q),
        .flags_q  (flags_q),
        .irq      (err_irq),
        .pending  (err_pending)
    );

    always_comb begin
        case (sel_q)
            SEL_CNT:   rd_data = cnt_q;
            SEL_FLAGS: rd_data = flags_q;
            SEL_MASK:  rd_data = mask_q;
            default:   rd_data = '0;
        endcase
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q != SEL_CNT) |-> (rd_data & ~DATA_W'(FLAG_KEEP)) == '0);

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        dec.start |=> cnt_q == $past(reload_q));

endmodule

// File: tb/bus_timeout_unit_tb.sv
module bus_timeout_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = 8'h00;
    logic       tick_slow = 1'b0;
    logic       tick_fast = 1'b0;
    logic       atn_active = 1'b0;
    logic       dav_active = 1'b0;
    logic       cnt_in = 1'b0;
    logic       ctl_req = 1'b0;
    logic       sys_ctrl = 1'b1;
    logic [7:0] rd_data;
    logic       err_pending;
    logic       err_irq;

    always #10 clk = ~clk;

    bus_timeout_unit dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wr_valid(wr_valid), .wr_data(wr_data), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .tick_slow(tick_slow), .tick_fast(tick_fast),
        .atn_active(atn_active), .dav_active(dav_active), .cnt_in(cnt_in),
        .ctl_req(ctl_req), .sys_ctrl(sys_ctrl), .rd_data(rd_data),
        .err_pending(err_pending), .err_irq(err_irq)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    int m_mode = 0;   // 0 idle, 1 atn, 2 activity, 3 dav
    int m_cnt = 0;
    int m_reload = 0;
    int m_flags = 0;
    int m_mask = 0;
    int m_sel = 0;    // 0 none, 1 count, 2 flags, 3 mask
    bit m_arm = 0;
    bit m_done = 0;
    bit m_prev = 0;

    function automatic int model_rd();
        case (m_sel)
            1: return m_cnt;
            2: return m_flags;
            3: return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit edge_seen;
        bit clr;
        bit start;
        int smode;
        int setv;
        edge_seen = m_prev && !cnt_in;
        m_prev = cnt_in;
        clr = 0; start = 0; smode = 0; setv = 0;
        if (cmd_valid) begin
            m_arm = (cmd_code == 8'hE1);
            case (cmd_code)
                8'hE9: m_sel = 1;
                8'hE4: m_sel = 2;
                8'hEA: m_sel = 3;
                8'hFA: begin start = 1; smode = 1; end
                8'hF4, 8'hF6: begin start = 1; smode = 2; end
                8'hFD: begin start = 1; smode = 3; end
                8'hF3: clr = 1;
                default: ;
            endcase
        end else if (wr_valid && m_arm) begin
            m_arm = 0;
            m_reload = wr_data;
        end
        if (mask_we) m_mask = mask_wdata & 8'h27;
        if (ctl_req && !sys_ctrl) setv |= 8'h20;
        if (clr) begin
            m_mode = 0;
        end else if (start) begin
            m_mode = smode;
            m_cnt = m_reload;
            m_done = 0;
        end else if (m_mode == 1 || m_mode == 3) begin
            if ((m_mode == 1 && !atn_active) || (m_mode == 3 && !dav_active)) begin
                m_mode = 0;
            end else if (tick_slow && !m_done) begin
                if (m_cnt == 1) begin
                    setv |= (m_mode == 1) ? 1 : 4;
                    m_done = 1;
                end
                m_cnt = (m_cnt + 255) % 256;
            end
        end else if (m_mode == 2) begin
            if (edge_seen) begin
                m_cnt = m_reload;
            end else if (tick_fast) begin
                if (m_cnt == 1) setv |= 2;
                m_cnt = (m_cnt + 255) % 256;
            end
        end
        if (clr) m_flags = 0;
        else m_flags |= setv;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 rd_data vs model", rd_data, model_rd());
        chk("R11 err_irq vs model", err_irq, ((m_flags & m_mask) != 0) ? 1 : 0);
        chk("R11 err_pending vs model", err_pending, (m_flags != 0) ? 1 : 0);
        cmd_valid = 0; wr_valid = 0; mask_we = 0;
        tick_slow = 0; tick_fast = 0; ctl_req = 0;
    endtask

    task automatic cmd(input logic [7:0] c);
        cmd_valid = 1; cmd_code = c; cyc();
    endtask
    task automatic wr(input logic [7:0] d);
        wr_valid = 1; wr_data = d; cyc();
    endtask
    task automatic mask(input logic [7:0] d);
        mask_we = 1; mask_wdata = d; cyc();
    endtask
    task automatic tslow(input int n);
        for (int i = 0; i < n; i++) begin tick_slow = 1; cyc(); end
    endtask
    task automatic tfast(input int n);
        for (int i = 0; i < n; i++) begin tick_fast = 1; cyc(); end
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        chk("R12 rd_data", rd_data, 0);
        chk("R12 err_irq", err_irq, 0);
        chk("R12 err_pending", err_pending, 0);

        // R2 mask readback and reserved bits
        mask(8'h27); cmd(8'hEA);
        chk("R2 mask readback", rd_data, 8'h27);
        mask(8'h01); cmd(8'hEA);
        chk("R2 mask rewrite", rd_data, 8'h01);

        // R1 unarmed write ignored; R3 reload 00 means 256 steps
        wr(8'h05);
        atn_active = 1;
        cmd(8'hFA); cmd(8'hE9);
        chk("R1 unarmed write ignored", rd_data, 8'h00);
        tslow(255);
        chk("R3 count after 255 steps", rd_data, 8'h01);
        chk("R3 no flag before 256th", err_pending, 0);
        tslow(1);
        chk("R4 expiry count", rd_data, 8'h00);
        chk("R4 expiry pending", err_pending, 1);
        chk("R11 masked irq", err_irq, 1);
        cmd(8'hE4);
        chk("R4 flag bit0", rd_data, 8'h01);
        cmd(8'hE9); tslow(2);
        chk("R7 count held at zero", rd_data, 8'h00);
        atn_active = 0; idle(1);
        cmd(8'hF3); cmd(8'hE4);
        chk("R8 flags cleared", rd_data, 8'h00);
        chk("R8 pending cleared", err_pending, 0);

        // R4 stop without expiry, R7 other rate ignored, R9 hold
        cmd(8'hE1); wr(8'h03);
        atn_active = 1;
        cmd(8'hFA); cmd(8'hE9);
        chk("R3 start loads reload", rd_data, 8'h03);
        tfast(2);
        chk("R7 fast strobe ignored in mode 1", rd_data, 8'h03);
        tslow(1);
        chk("R4 one step", rd_data, 8'h02);
        atn_active = 0; idle(1); tslow(2);
        chk("R9 idle count kept", rd_data, 8'h02);
        chk("R4 no flag after early stop", err_pending, 0);

        // R5 activity mode
        cmd(8'hE1); wr(8'h04);
        cmd(8'hF4); cmd(8'hE9);
        tfast(2);
        chk("R5 two fast steps", rd_data, 8'h02);
        cnt_in = 1; idle(1); cnt_in = 0; idle(1);
        chk("R5 edge reload", rd_data, 8'h04);
        tslow(1);
        chk("R7 slow strobe ignored in mode 2", rd_data, 8'h04);
        tfast(4);
        chk("R5 expiry count", rd_data, 8'h00);
        cmd(8'hE4);
        chk("R5 flag bit1", rd_data, 8'h02);
        cmd(8'hE9); tfast(1);
        chk("R5 wrap to 256 period", rd_data, 8'hFF);
        tfast(255);
        chk("R5 second period end", rd_data, 8'h00);
        cnt_in = 1; idle(1); cnt_in = 0; idle(1);
        chk("R5 edge after expiry", rd_data, 8'h04);
        cmd(8'hE1); wr(8'h06); cmd(8'hF6); cmd(8'hE9);
        chk("R5 standby start", rd_data, 8'h06);
        cmd(8'hF3);

        // R6 data-valid mode and R7 persistence
        dav_active = 1;
        cmd(8'hE1); wr(8'h02);
        cmd(8'hFD); cmd(8'hE9);
        tslow(2);
        chk("R6 expiry count", rd_data, 8'h00);
        cmd(8'hE4);
        chk("R6 flag bit2", rd_data, 8'h04);
        mask(8'h04);
        chk("R11 irq on bit2", err_irq, 1);
        cmd(8'hE1); wr(8'h09); cmd(8'hE9); tslow(1);
        chk("R7 monitoring survives commands", rd_data, 8'h00);
        dav_active = 0; idle(1);
        cmd(8'hF3); cmd(8'hE4);
        chk("R8 flags cleared again", rd_data, 8'h00);
        cmd(8'hE9);
        chk("R8 count left as it was", rd_data, 8'h00);

        // R10 user error
        sys_ctrl = 1; ctl_req = 1; cyc();
        cmd(8'hE4);
        chk("R10 no flag as controller", rd_data, 8'h00);
        sys_ctrl = 0; ctl_req = 1; cyc();
        chk("R10 user flag bit5", rd_data, 8'h20);
        mask(8'h20);
        chk("R11 irq on user flag", err_irq, 1);
        mask(8'h07);
        chk("R11 masked off irq", err_irq, 0);
        chk("R11 pending unmasked", err_pending, 1);
        cmd(8'hF3);
        chk("R8 user flag cleared", rd_data, 8'h00);

        finish_run();
    end

endmodule